// File: doc/BRIEF.md
# GPIO Port with Peripheral Override

An eight-pin general-purpose I/O port. A small register bus reaches three locations: the output data latch, the pin direction register and a read-only view of the synchronized pad inputs. When no peripheral owns a pin, the direction bit sets the pad's output enable and the data latch sets the value the pad drives.

Serial peripherals can take pins over. Each of two UART channels owns a pair of pins: its receive pin is forced to input and its transmit pin is forced to output and driven from the channel's transmit signal. An enabled SPI owns the upper four pins. For those pins it supplies the direction and the value driven. Overrides act only on the pads. The stored direction bits never change, and a pin goes back to register control as soon as its peripheral is disabled. Pad inputs pass through a two-flop synchronizer before any register read can see them.

Top module: `gpio_override_port`

## Requirements
- R1: After reset the direction register and the data latch are 0x00, so every `pad_oe` bit is 0 and every `pad_out` bit is 0.
- R2: On a pin no peripheral owns, `pad_oe[i]` equals direction bit i (1 = output, 0 = input) and `pad_out[i]` equals data latch bit i.
- R3: The direction register at offset 1 can be written and read back at any time and returns exactly the last value written.
- R4: While UART channel k (`uart_en[k]`) is enabled, pin 2k is its receive pin, with `pad_oe` 0 and `pad_out` 0, and pin 2k+1 is its transmit pin, with `pad_oe` 1 and `pad_out` equal to `uart_tx[k]`. The direction bits of those pins are ignored.
- R5: While `spi_en` is 1, pin 4+j has `pad_oe` equal to `spi_dir[j]` and `pad_out` equal to `spi_out[j]`, for j = 0..3.
- R6: Peripheral overrides never alter the stored direction bits. Once a peripheral is disabled, its pins follow the direction register and data latch again.
- R7: A read at offset 2 returns `pad_in` as sampled by two flops in series. A change on `pad_in` shows up after the second rising edge and not after the first.
- R8: A read at offset 0 returns, for each bit, the data latch where the direction bit is 1 and the synchronized pad input where it is 0.
- R9: A write at offset 0 loads the data latch. Writes at offsets 2 and 3 change no register, and a read at offset 3 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 2 | Register offset: 0 data, 1 direction, 2 pin input, 3 reserved |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pad_in | input | 8 | Raw pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables, 1 = drive |
| uart_en | input | 2 | Per-channel UART enable |
| uart_tx | input | 2 | Per-channel UART transmit value |
| spi_en | input | 1 | SPI enable |
| spi_dir | input | 4 | SPI per-pin direction for pins 4..7, 1 = output |
| spi_out | input | 4 | SPI per-pin output value for pins 4..7 |

## Verification
The pin mux is driven in four configurations: no peripheral enabled, one UART channel enabled over an all-input direction register, the other UART channel enabled over an all-output direction register, and the SPI enabled with a mixed direction pattern. These separate a forced output from a forced input and show that each override stays on its own pins. Direction is read back during each override and after it is removed, which shows that overrides never write the register. The pad-input path is sampled one edge and two edges after a pad change, which tells a two-flop delay from a one-flop delay. Mixed direction patterns on data reads tell the latch source apart from the pad source bit by bit.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;

   localparam int unsigned REG_AW = 2;

   typedef enum logic [REG_AW-1:0] {
      OFS_DATA = 2'd0,
      OFS_DIR  = 2'd1,
      OFS_PIN  = 2'd2,
      OFS_RSVD = 2'd3
   } reg_ofs_e;

   typedef enum logic [1:0] {
      OWN_PORT    = 2'd0,
      OWN_UART_RX = 2'd1,
      OWN_UART_TX = 2'd2,
      OWN_SPI     = 2'd3
   } pin_owner_e;

endpackage

// File: rtl/gpio_ovr_sync.sv
module gpio_ovr_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/gpio_ovr_regs.sv
module gpio_ovr_regs
   import gpio_ovr_pkg::*;
#(
   parameter int unsigned PIN_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] addr,
   input  logic [PIN_W-1:0]  wdata,
   input  logic [PIN_W-1:0]  pin_sync,
   output logic [PIN_W-1:0]  rdata,
   output logic [PIN_W-1:0]  data_q,
   output logic [PIN_W-1:0]  dir_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         dir_q  <= '0;
      end else if (wr_en) begin
         if (addr == OFS_DATA) data_q <= wdata;
         if (addr == OFS_DIR)  dir_q  <= wdata;
      end
   end

   always_comb begin
      unique case (reg_ofs_e'(addr))
         OFS_DATA: rdata = (data_q & dir_q) | (pin_sync & ~dir_q);
         OFS_DIR:  rdata = dir_q;
         OFS_PIN:  rdata = pin_sync;
         default:  rdata = '0;
      endcase
   end

endmodule

// File: rtl/gpio_ovr_pinmux.sv
module gpio_ovr_pinmux
   import gpio_ovr_pkg::*;
#(
   parameter int unsigned PIN_W    = 8,
   parameter int unsigned N_UART   = 2,
   parameter int unsigned SPI_PINS = 4
) (
   input  logic [PIN_W-1:0]    dir_q,
   input  logic [PIN_W-1:0]    data_q,
   input  logic [N_UART-1:0]   uart_en,
   input  logic [N_UART-1:0]   uart_tx,
   input  logic                spi_en,
   input  logic [SPI_PINS-1:0] spi_dir,
   input  logic [SPI_PINS-1:0] spi_out,
   output logic [PIN_W-1:0]    pad_out,
   output logic [PIN_W-1:0]    pad_oe
);

   localparam int unsigned UART_PINS = 2 * N_UART;
   localparam int unsigned SPI_BASE  = UART_PINS;
   localparam int unsigned SPI_END   = SPI_BASE + SPI_PINS;

   for (genvar i = 0; i < PIN_W; i++) begin : g_pin
      pin_owner_e owner;

      if (i < UART_PINS) begin : g_uart
         localparam int unsigned CH    = i / 2;
         localparam bit          IS_TX = (i % 2) == 1;
         always_comb begin
            if (!uart_en[CH]) owner = OWN_PORT;
            else if (IS_TX)   owner = OWN_UART_TX;
            else              owner = OWN_UART_RX;
         end
         always_comb begin
            unique case (owner)
               OWN_UART_TX: begin pad_oe[i] = 1'b1; pad_out[i] = uart_tx[CH]; end
               OWN_UART_RX: begin pad_oe[i] = 1'b0; pad_out[i] = 1'b0;        end
               default:     begin pad_oe[i] = dir_q[i]; pad_out[i] = data_q[i]; end
            endcase
         end
      end else if (i < SPI_END) begin : g_spi
         localparam int unsigned J = i - SPI_BASE;
         assign owner = spi_en ? OWN_SPI : OWN_PORT;
         always_comb begin
            if (owner == OWN_SPI) begin
               pad_oe[i]  = spi_dir[J];
               pad_out[i] = spi_out[J];
            end else begin
               pad_oe[i]  = dir_q[i];
               pad_out[i] = data_q[i];
            end
         end
      end else begin : g_plain
         assign owner      = OWN_PORT;
         assign pad_oe[i]  = dir_q[i];
         assign pad_out[i] = data_q[i];
      end
   end

endmodule

// File: rtl/gpio_override_port.sv
module gpio_override_port
   import gpio_ovr_pkg::*;
#(
   parameter int unsigned PIN_W       = 8,
   parameter int unsigned N_UART      = 2,
   parameter int unsigned SPI_PINS    = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_sel,
   input  logic                bus_wr,
   input  logic [REG_AW-1:0]   bus_addr,
   input  logic [PIN_W-1:0]    bus_wdata,
   output logic [PIN_W-1:0]    bus_rdata,
   input  logic [PIN_W-1:0]    pad_in,
   output logic [PIN_W-1:0]    pad_out,
   output logic [PIN_W-1:0]    pad_oe,
   input  logic [N_UART-1:0]   uart_en,
   input  logic [N_UART-1:0]   uart_tx,
   input  logic                spi_en,
   input  logic [SPI_PINS-1:0] spi_dir,
   input  logic [SPI_PINS-1:0] spi_out
);

   localparam int unsigned OWNED_PINS = 2 * N_UART + SPI_PINS;

   if (OWNED_PINS > PIN_W) begin : g_bad_map
      $error("peripheral pins exceed port width");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("synchronizer needs at least two stages");
   end

   logic             wr_en;
   logic [PIN_W-1:0] sync_q;
   logic [PIN_W-1:0] data_q;
   logic [PIN_W-1:0] dir_q;

   assign wr_en = bus_sel & bus_wr;

   gpio_ovr_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (sync_q)
   );

   gpio_ovr_regs #(.PIN_W(PIN_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .addr     (bus_addr),
      .wdata    (bus_wdata),
      .pin_sync (sync_q),
      .rdata    (bus_rdata),
      .data_q   (data_q),
      .dir_q    (dir_q)
   );

   gpio_ovr_pinmux #(.PIN_W(PIN_W), .N_UART(N_UART), .SPI_PINS(SPI_PINS)) u_mux (
      .dir_q   (dir_q),
      .data_q  (data_q),
      .uart_en (uart_en),
      .uart_tx (uart_tx),
      .spi_en  (spi_en),
      .spi_dir (spi_dir),
      .spi_out (spi_out),
      .pad_out (pad_out),
      .pad_oe  (pad_oe)
   );

endmodule

// File: rtl/gpio_override_port_chk.sv
module gpio_override_port_chk
   import gpio_ovr_pkg::*;
#(
   parameter int unsigned PIN_W       = 8,
   parameter int unsigned N_UART      = 2,
   parameter int unsigned SPI_PINS    = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic                wr_en,
   input logic [REG_AW-1:0]   bus_addr,
   input logic [PIN_W-1:0]    bus_wdata,
   input logic [PIN_W-1:0]    pad_in,
   input logic [PIN_W-1:0]    pad_out,
   input logic [PIN_W-1:0]    pad_oe,
   input logic [PIN_W-1:0]    dir_q,
   input logic [PIN_W-1:0]    sync_q,
   input logic [N_UART-1:0]   uart_en,
   input logic [N_UART-1:0]   uart_tx,
   input logic                spi_en,
   input logic [SPI_PINS-1:0] spi_dir
);

   localparam int unsigned SPI_BASE = 2 * N_UART;

   logic [1:0] live_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               live_cnt <= '0;
      else if (live_cnt != 2'd3) live_cnt <= live_cnt + 2'd1;
   end

   for (genvar k = 0; k < N_UART; k++) begin : g_uart_chk
      AST_UART_TX_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
         uart_en[k] |-> (pad_oe[2*k+1] && pad_out[2*k+1] == uart_tx[k])); // R4
      AST_UART_RX_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
         uart_en[k] |-> (!pad_oe[2*k] && !pad_out[2*k])); // R4
      AST_UART_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
         !uart_en[k] |-> (pad_oe[2*k+1 -: 2] == dir_q[2*k+1 -: 2])); // R6
   end

   AST_SPI_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
      spi_en |-> (pad_oe[SPI_BASE +: SPI_PINS] == spi_dir)); // R5

   AST_DIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && bus_addr == OFS_DIR) |=> $stable(dir_q)); // R6

   AST_DIR_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && bus_addr == OFS_DIR) |=> (dir_q == $past(bus_wdata))); // R3

   if (SYNC_STAGES == 2) begin : g_lat_chk
      AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
         (live_cnt >= 2'd2) |-> (sync_q == $past(pad_in, 2))); // R7
   end

endmodule

bind gpio_override_port gpio_override_port_chk #(
   .PIN_W(PIN_W), .N_UART(N_UART), .SPI_PINS(SPI_PINS), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .pad_in    (pad_in),
   .pad_out   (pad_out),
   .pad_oe    (pad_oe),
   .dir_q     (dir_q),
   .sync_q    (sync_q),
   .uart_en   (uart_en),
   .uart_tx   (uart_tx),
   .spi_en    (spi_en),
   .spi_dir   (spi_dir)
);

// File: tb/gpio_override_port_test.sv
module gpio_override_port_test;

   localparam int unsigned PERIOD_NS = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0;
   logic       bus_wr = 1'b0;
   logic [1:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [7:0] pad_in = '0;
   logic [7:0] pad_out;
   logic [7:0] pad_oe;
   logic [1:0] uart_en = '0;
   logic [1:0] uart_tx = '0;
   logic       spi_en = 1'b0;
   logic [3:0] spi_dir = '0;
   logic [3:0] spi_out = '0;

   always #(PERIOD_NS/2) clk = ~clk;

   gpio_override_port uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
      .uart_en(uart_en), .uart_tx(uart_tx), .spi_en(spi_en),
      .spi_dir(spi_dir), .spi_out(spi_out)
   );

   typedef enum int {PR_RDATA, PR_OE, PR_OUT} probe_e;
   typedef struct {
      probe_e     probe;
      logic [7:0] exp;
      string      tag;
   } item_t;

   item_t exp_q [$];
   event  ev_sample;
   int    n_chk = 0;
   int    n_fail = 0;
   bit    done = 1'b0;

   // monitor: pops one expected item per sample event and compares
   always @(ev_sample) begin
      while (exp_q.size() > 0) begin
         item_t it;
         logic [7:0] act;
         it = exp_q.pop_front();
         case (it.probe)
            PR_RDATA: act = bus_rdata;
            PR_OE:    act = pad_oe;
            default:  act = pad_out;
         endcase
         n_chk++;
         if (act !== it.exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", it.tag, act, it.exp);
         end
      end
   end

   task automatic expect_val(input probe_e p, input logic [7:0] e, input string tag);
      item_t it;
      #1;
      it.probe = p; it.exp = e; it.tag = tag;
      exp_q.push_back(it);
      -> ev_sample;
      #1;
   endtask

   task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
      bus_addr = a;
      expect_val(PR_RDATA, e, tag);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   initial begin
      #(200000 * PERIOD_NS);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(2'd1, 8'h00, "R1 dir reset");
      expect_val(PR_OE, 8'h00, "R1 oe reset");
      expect_val(PR_OUT, 8'h00, "R1 out reset");
      rd(2'd0, 8'h00, "R1 data reset");

      // R3 / R2 direction drives oe
      wr(2'd1, 8'hF0);
      rd(2'd1, 8'hF0, "R3 dir readback F0");
      expect_val(PR_OE, 8'hF0, "R2 oe follows dir");
      wr(2'd0, 8'h3C);
      expect_val(PR_OUT, 8'h3C, "R2 out follows latch");

      // R8 mixed read
      pad_in = 8'h5A;
      repeat (2) @(negedge clk);
      rd(2'd0, 8'h3A, "R8 data read mix");

      // R7 two-flop latency
      @(negedge clk);
      pad_in = 8'hC3;
      @(negedge clk);
      rd(2'd2, 8'h5A, "R7 one edge still old");
      @(negedge clk);
      rd(2'd2, 8'hC3, "R7 two edges new");

      // R9 ignored writes and reserved read
      wr(2'd2, 8'hFF);
      rd(2'd1, 8'hF0, "R9 pin write leaves dir");
      rd(2'd0, 8'h33, "R9 pin write leaves latch");
      rd(2'd2, 8'hC3, "R9 pin write leaves pin reg");
      wr(2'd3, 8'hAA);
      rd(2'd3, 8'h00, "R9 reserved reads zero");
      rd(2'd1, 8'hF0, "R9 reserved write leaves dir");

      wr(2'd1, 8'h0F);
      rd(2'd1, 8'h0F, "R3 dir readback 0F");

      // R4 UART channel 0 over all-input dir
      wr(2'd1, 8'h00);
      wr(2'd0, 8'h00);
      @(negedge clk);
      uart_en = 2'b01; uart_tx = 2'b01;
      expect_val(PR_OE, 8'h02, "R4 uart0 oe");
      expect_val(PR_OUT, 8'h02, "R4 uart0 out");
      uart_tx = 2'b00;
      expect_val(PR_OUT, 8'h00, "R4 uart0 tx low");

      // R4 UART channel 1 over all-output dir
      uart_en = 2'b00;
      wr(2'd1, 8'hFF);
      wr(2'd0, 8'hFF);
      @(negedge clk);
      uart_en = 2'b10; uart_tx = 2'b00;
      expect_val(PR_OE, 8'hFB, "R4 uart1 oe");
      expect_val(PR_OUT, 8'hF3, "R4 uart1 out");

      // R6 stored dir intact, release
      rd(2'd1, 8'hFF, "R6 dir kept under uart");
      @(negedge clk);
      uart_en = 2'b00;
      expect_val(PR_OE, 8'hFF, "R6 uart release oe");
      expect_val(PR_OUT, 8'hFF, "R6 uart release out");

      // R5 SPI
      wr(2'd1, 8'h00);
      @(negedge clk);
      spi_en = 1'b1; spi_dir = 4'b1010; spi_out = 4'b0110;
      expect_val(PR_OE, 8'hA0, "R5 spi oe");
      expect_val(PR_OUT, 8'h6F, "R5 spi out");
      rd(2'd1, 8'h00, "R6 dir kept under spi");
      @(negedge clk);
      spi_en = 1'b0;
      expect_val(PR_OE, 8'h00, "R6 spi release oe");
      expect_val(PR_OUT, 8'hFF, "R6 spi release out");

      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule